// File: doc/BRIEF.md
# Codec Audio Input Frame Serializer

This block produces the codec-to-controller direction of a five-wire audio codec link. It generates the link bit clock from a faster core clock and watches the frame sync input. On each sync rising edge it captures one set of inputs and streams a 256-bit frame out on the serial data line. The captured inputs are a register read-back (index plus 16-bit value), a left and a right 18-bit record sample, and their valid flags. Each bit leaves on a rising bit clock edge, most significant bit first.

The frame is a 16-bit tag slot followed by twelve 20-bit slots. The tag announces codec readiness and which slots carry data. Slot 1 echoes the register index and slot 2 carries the read value. Slots 3 and 4 hold the left and right samples, left-justified. Every other position is zero. A write of the power-down bit to the power-control register index forces the bit clock and the data line low. The link stays silent until the reset input is applied.

Top module: `codec_in_serializer`

## Requirements
- R1: `bit_clk_o` is a square wave with a period of 2*BCLK_HALF core clocks, and `sdata_o` changes only in the core cycle in which `bit_clk_o` rises.
- R2: `sync_i` is sampled at every rising bit clock edge. When it is seen 1 after being seen 0, the next 256 rising edges carry frame bits 0..255, starting with tag bit 15. Afterwards `sdata_o` is 0 until a new frame starts. A new sync rise always restarts the frame.
- R3: Tag slot bit 15 = codec ready, bit 14 = slot 1 valid, bit 13 = slot 2 valid, bit 12 = slot 3 valid, bit 11 = slot 4 valid, and bits 10..0 are 0. With codec ready low, the whole tag and every slot are 0.
- R4: With status valid, slot 1 holds the 7-bit register index in bits 18..12, and its other bits are 0.
- R5: With status valid, slot 2 holds the 16-bit read value in bits 19..4, and bits 3..0 are 0.
- R6: With status invalid, the slot 1 and slot 2 tag flags are 0 and both slots are all zero, whatever the index and data inputs hold.
- R7: Slot 3 carries the left sample and slot 4 the right sample, each in bits 19..2 with bits 1..0 zero. A sample whose valid flag is low gives an all-zero slot.
- R8: Slots 5 to 12 are always all zero.
- R9: All frame inputs are captured at the rising bit clock edge that detects the sync rise. Changes after that edge do not alter the frame in progress.
- R10: A write strobe with index 0x26 and data bit 12 set brings `bit_clk_o` and `sdata_o` to 0 two core clocks later. Both then stay 0 while `sync_i` toggles.
- R11: Only `rst_n` leaves the power-down state. A write to another index, or to index 0x26 with bit 12 clear, leaves the link running.
- R12: While `rst_n` is low, `bit_clk_o` and `sdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller |
| codec_ready_i | input | 1 | Codec ready indication for the tag |
| stat_valid_i | input | 1 | Register read-back is valid |
| stat_addr_i | input | 7 | Index of the register read back |
| stat_data_i | input | 16 | Register read-back value |
| left_valid_i | input | 1 | Left sample valid |
| left_i | input | 18 | Left record sample |
| right_valid_i | input | 1 | Right sample valid |
| right_i | input | 18 | Right record sample |
| pwr_wr_i | input | 1 | Register write strobe |
| pwr_addr_i | input | 7 | Register write index |
| pwr_data_i | input | 16 | Register write value |
| bit_clk_o | output | 1 | Link bit clock |
| sdata_o | output | 1 | Serial frame data |

## Verification
A slip in the slot or bit position counters shows as every later field of the frame shifted or misplaced. It is seen within one frame of 256 bit clocks, usually in the next slot compared. A bad capture register shows as a slot that follows the live inputs instead of the values present at the sync edge. Bench frames change the inputs halfway through to expose this. A wrong power-down flag shows at once: the bit clock keeps running when it should stop, or it stops when it should not.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 13;
  localparam int IDX_W      = 7;
  localparam int REG_W      = 16;
  localparam int SMP_W      = 18;
  localparam int SLOT_IW    = $clog2(NUM_SLOTS);
  localparam int BIT_IW     = $clog2(SLOT_W);

  typedef struct packed {
    logic              ready;
    logic              stat_v;
    logic [IDX_W-1:0]  stat_addr;
    logic [REG_W-1:0]  stat_data;
    logic              left_v;
    logic [SMP_W-1:0]  left;
    logic              right_v;
    logic [SMP_W-1:0]  right;
  } frame_in_t;

  // Tag: ready, then one valid flag per slot 1..4; slots 5..12 never flagged.
  function automatic logic [TAG_W-1:0] tag_word(input frame_in_t f);
    logic [TAG_W-1:0] t;
    t = '0;
    if (f.ready)
      t = {1'b1, f.stat_v, f.stat_v, f.left_v, f.right_v, {(TAG_W-5){1'b0}}};
    return t;
  endfunction

  // 20-bit content of a slot, left-justified, zero filled.
  function automatic logic [SLOT_W-1:0] slot_word(input frame_in_t f,
                                                   input logic [SLOT_IW-1:0] s);
    logic [SLOT_W-1:0] w;
    w = '0;
    if (f.ready) begin
      case (s)
        SLOT_IW'(0): w[TAG_W-1:0] = tag_word(f);
        SLOT_IW'(1): if (f.stat_v)
                       w = {1'b0, f.stat_addr, {(SLOT_W-1-IDX_W){1'b0}}};
        SLOT_IW'(2): if (f.stat_v)  w = {f.stat_data, {(SLOT_W-REG_W){1'b0}}};
        SLOT_IW'(3): if (f.left_v)  w = {f.left,  {(SLOT_W-SMP_W){1'b0}}};
        SLOT_IW'(4): if (f.right_v) w = {f.right, {(SLOT_W-SMP_W){1'b0}}};
        default:     w = '0;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/cif_bitclk.sv
module cif_bitclk #(
  parameter int BCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic bclk_o,
  output logic rise_o
);
  localparam int CW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(BCLK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          edge_due;

  assign edge_due = (cnt_q == LAST);
  assign rise_o   = edge_due && !bclk_o && !hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (edge_due) begin
      cnt_q  <= '0;
      bclk_o <= ~bclk_o;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  // R1
  rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> bclk_o);

  // R1
  half_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !edge_due) |=> $stable(bclk_o));
endmodule

// File: rtl/cif_seq.sv
module cif_seq
  import cif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               restart_i,
  input  logic               kill_i,
  output logic               active_o,
  output logic [SLOT_IW-1:0] slot_o,
  output logic [BIT_IW-1:0]  bit_o
);
  localparam logic [SLOT_IW-1:0] LAST_SLOT = SLOT_IW'(NUM_SLOTS - 1);
  localparam logic [BIT_IW-1:0]  TAG_TOP   = BIT_IW'(TAG_W - 1);
  localparam logic [BIT_IW-1:0]  SLOT_TOP  = BIT_IW'(SLOT_W - 1);

  logic frame_end;
  assign frame_end = active_o && (slot_o == LAST_SLOT) && (bit_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      slot_o   <= '0;
      bit_o    <= '0;
    end else if (kill_i) begin
      active_o <= 1'b0;
    end else if (step_i) begin
      if (restart_i) begin
        active_o <= 1'b1;
        slot_o   <= '0;
        bit_o    <= TAG_TOP;
      end else if (active_o) begin
        if (bit_o == '0) begin
          if (slot_o == LAST_SLOT) begin
            active_o <= 1'b0;
          end else begin
            slot_o <= slot_o + SLOT_IW'(1);
            bit_o  <= SLOT_TOP;
          end
        end else begin
          bit_o <= bit_o - BIT_IW'(1);
        end
      end
    end
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (slot_o <= LAST_SLOT &&
                  bit_o <= ((slot_o == '0) ? TAG_TOP : SLOT_TOP)));

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !restart_i && !kill_i && frame_end) |=> !active_o);
endmodule

// File: rtl/cif_packer.sv
module cif_packer
  import cif_pkg::*;
(
  input  frame_in_t          frm_i,
  input  logic [SLOT_IW-1:0] slot_i,
  input  logic [BIT_IW-1:0]  bit_i,
  output logic               bit_o
);
  logic [SLOT_W-1:0] words [NUM_SLOTS];
  logic [SLOT_W-1:0] cur_word;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign words[g] = slot_word(frm_i, SLOT_IW'(g));
  end

  assign cur_word = (int'(slot_i) < NUM_SLOTS) ? words[slot_i] : '0;
  assign bit_o    = (int'(bit_i) < SLOT_W) ? cur_word[bit_i] : 1'b0;
endmodule

// File: rtl/codec_in_serializer.sv
module codec_in_serializer
  import cif_pkg::*;
#(
  parameter int              BCLK_HALF = 2,
  parameter logic [6:0]      PD_ADDR   = 7'h26,
  parameter int              PD_BIT    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_i,
  input  logic        codec_ready_i,
  input  logic        stat_valid_i,
  input  logic [6:0]  stat_addr_i,
  input  logic [15:0] stat_data_i,
  input  logic        left_valid_i,
  input  logic [17:0] left_i,
  input  logic        right_valid_i,
  input  logic [17:0] right_i,
  input  logic        pwr_wr_i,
  input  logic [6:0]  pwr_addr_i,
  input  logic [15:0] pwr_data_i,
  output logic        bit_clk_o,
  output logic        sdata_o
);
  frame_in_t          live_in;
  frame_in_t          frm_q;
  logic               rise_evt;
  logic               sync_q;
  logic               sync_rise;
  logic               pd_q;
  logic               pd_hit;
  logic               seq_active;
  logic [SLOT_IW-1:0] seq_slot;
  logic [BIT_IW-1:0]  seq_bit;
  logic               pack_bit;

  always_comb begin
    live_in.ready     = codec_ready_i;
    live_in.stat_v    = stat_valid_i;
    live_in.stat_addr = stat_addr_i;
    live_in.stat_data = stat_data_i;
    live_in.left_v    = left_valid_i;
    live_in.left      = left_i;
    live_in.right_v   = right_valid_i;
    live_in.right     = right_i;
  end

  assign sync_rise = rise_evt && sync_i && !sync_q;
  assign pd_hit    = pwr_wr_i && (pwr_addr_i == PD_ADDR) && pwr_data_i[PD_BIT];

  cif_bitclk #(.BCLK_HALF(BCLK_HALF)) u_bclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (pd_q),
    .bclk_o (bit_clk_o),
    .rise_o (rise_evt)
  );

  cif_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (rise_evt),
    .restart_i (sync_rise),
    .kill_i    (pd_q),
    .active_o  (seq_active),
    .slot_o    (seq_slot),
    .bit_o     (seq_bit)
  );

  cif_packer u_pack (
    .frm_i  (frm_q),
    .slot_i (seq_slot),
    .bit_i  (seq_bit),
    .bit_o  (pack_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      frm_q  <= '0;
      pd_q   <= 1'b0;
    end else begin
      if (rise_evt) sync_q <= sync_i;
      if (sync_rise) frm_q <= live_in;
      if (pd_hit) pd_q <= 1'b1;
    end
  end

  // Last bit of the old frame leaves on the same edge that captures the new one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdata_o <= 1'b0;
    else if (pd_q)     sdata_o <= 1'b0;
    else if (rise_evt) sdata_o <= seq_active ? pack_bit : 1'b0;
  end

  // R10
  pd_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> (!bit_clk_o && !sdata_o));

  // R11
  pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> pd_q);

  // R1
  sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_evt && !pd_q) |=> $stable(sdata_o));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !pd_q && !seq_active) |=> !sdata_o);

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !pd_q && seq_active && seq_slot > SLOT_IW'(4)) |=> !sdata_o);

  // R6
  invalid_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !pd_q && seq_active && !frm_q.stat_v &&
     (seq_slot == SLOT_IW'(1) || seq_slot == SLOT_IW'(2))) |=> !sdata_o);
endmodule

// File: tb/test_codec_in_serializer.sv
module test_codec_in_serializer;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic        codec_ready_i = 1'b0;
  logic        stat_valid_i = 1'b0;
  logic [6:0]  stat_addr_i = '0;
  logic [15:0] stat_data_i = '0;
  logic        left_valid_i = 1'b0;
  logic [17:0] left_i = '0;
  logic        right_valid_i = 1'b0;
  logic [17:0] right_i = '0;
  logic        pwr_wr_i = 1'b0;
  logic [6:0]  pwr_addr_i = '0;
  logic [15:0] pwr_data_i = '0;
  logic        bit_clk_o;
  logic        sdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  int mon_bad = 0;
  logic prev_b = 1'b0;
  logic prev_s = 1'b0;

  always #4ns clk = ~clk;

  codec_in_serializer #(.BCLK_HALF(HALF)) i_codec_in_serializer (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .codec_ready_i(codec_ready_i),
    .stat_valid_i(stat_valid_i), .stat_addr_i(stat_addr_i), .stat_data_i(stat_data_i),
    .left_valid_i(left_valid_i), .left_i(left_i), .right_valid_i(right_valid_i),
    .right_i(right_i), .pwr_wr_i(pwr_wr_i), .pwr_addr_i(pwr_addr_i),
    .pwr_data_i(pwr_data_i), .bit_clk_o(bit_clk_o), .sdata_o(sdata_o)
  );

  // R1 monitor: data may only move together with a bit clock rise
  always @(negedge clk) begin
    if (mon_en && (sdata_o !== prev_s) && !(bit_clk_o && !prev_b)) mon_bad++;
    prev_b <= bit_clk_o;
    prev_s <= sdata_o;
  end

  task automatic chk(input bit ok, input string req,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = bit_clk_o;
    forever begin
      @(negedge clk);
      if (bit_clk_o && !p) break;
      p = bit_clk_o;
    end
  endtask

  // Expected frame, written as field concatenation
  function automatic logic [255:0] model(input logic rdy, input logic sv,
      input logic [6:0] a, input logic [15:0] d, input logic lv,
      input logic [17:0] l, input logic rv, input logic [17:0] r);
    logic [15:0] tag;
    logic [19:0] s1, s2, s3, s4;
    tag = 16'h0; s1 = 20'h0; s2 = 20'h0; s3 = 20'h0; s4 = 20'h0;
    if (rdy) begin
      tag[15] = 1'b1; tag[14] = sv; tag[13] = sv; tag[12] = lv; tag[11] = rv;
      if (sv) begin s1[18:12] = a; s2[19:4] = d; end
      if (lv) s3[19:2] = l;
      if (rv) s4[19:2] = r;
    end
    return {tag, s1, s2, s3, s4, 160'h0};
  endfunction

  function automatic string req_of(input int s, input logic sv);
    if (s == 0) return "R3 tag slot";
    if (s <= 2 && !sv) return "R6 invalid status slot";
    if (s == 1) return "R4 index slot";
    if (s == 2) return "R5 data slot";
    if (s <= 4) return "R7 sample slot";
    return "R8 unused slot";
  endfunction

  task automatic randomize_inputs();
    codec_ready_i = ($urandom % 8) != 0;
    stat_valid_i  = ($urandom % 3) != 0;
    stat_addr_i   = 7'($urandom);
    stat_data_i   = 16'($urandom);
    left_valid_i  = ($urandom % 4) != 0;
    left_i        = 18'($urandom);
    right_valid_i = ($urandom % 4) != 0;
    right_i       = 18'($urandom);
  endtask

  task automatic start_frame();
    @(negedge clk);
    sync_i = 1'b1;
    wait_rise();
  endtask

  // Receives one frame whose sync edge has just been detected.
  task automatic do_frame(input bit chain_next, input bit scramble);
    logic [255:0] exp, rx;
    logic sv;
    sv  = codec_ready_i & stat_valid_i;
    exp = model(codec_ready_i, stat_valid_i, stat_addr_i, stat_data_i,
                left_valid_i, left_i, right_valid_i, right_i);
    rx = '0;
    for (int i = 0; i < 256; i++) begin
      wait_rise();
      rx[255 - i] = sdata_o;
      if (i == 15) sync_i = 1'b0;
      if (i == 100 && scramble) randomize_inputs();
      if (i == 254 && chain_next) sync_i = 1'b1;
    end
    chk(rx[255:240] == exp[255:240], req_of(0, sv),
        256'(rx[255:240]), 256'(exp[255:240]));
    for (int s = 1; s < 13; s++) begin
      chk(rx[259 - 20*s -: 20] == exp[259 - 20*s -: 20], req_of(s, sv),
          256'(rx[259 - 20*s -: 20]), 256'(exp[259 - 20*s -: 20]));
    end
    // R9: whole frame reflects inputs captured at the sync edge
    chk(rx == exp, "R9 captured frame", rx, exp);
  endtask

  initial begin
    int n;
    logic p;
    bit ok;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(!bit_clk_o && !sdata_o, "R12 reset outputs", 256'({bit_clk_o, sdata_o}), 256'(0));
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R1 bit clock period
    wait_rise();
    n = 0; p = 1'b1;
    forever begin
      @(negedge clk); n++;
      if (bit_clk_o && !p) break;
      p = bit_clk_o;
    end
    chk(n == 2*HALF, "R1 bit clock period", 256'(n), 256'(2*HALF));

    // Directed: all valid, all-ones fields (R4, R5, R7 trailing zeros)
    codec_ready_i = 1; stat_valid_i = 1; stat_addr_i = 7'h7f; stat_data_i = 16'hffff;
    left_valid_i = 1; left_i = 18'h3ffff; right_valid_i = 1; right_i = 18'h3ffff;
    start_frame(); do_frame(1'b0, 1'b1);

    // Directed: status invalid with busy index/data (R6)
    codec_ready_i = 1; stat_valid_i = 0; stat_addr_i = 7'h26; stat_data_i = 16'hbeef;
    left_valid_i = 0; left_i = 18'h2aaaa; right_valid_i = 1; right_i = 18'h15555;
    start_frame(); do_frame(1'b0, 1'b1);

    // Directed: codec not ready (R3)
    codec_ready_i = 0; stat_valid_i = 1; stat_addr_i = 7'h11; stat_data_i = 16'h1234;
    left_valid_i = 1; left_i = 18'h12345; right_valid_i = 1; right_i = 18'h23456;
    start_frame(); do_frame(1'b0, 1'b1);

    // Random back-to-back frames: sync rise coincides with bit 255 (R2, R9)
    randomize_inputs();
    start_frame();
    for (int f = 0; f < 8; f++) do_frame(f != 7, 1'b1);

    // R2 idle after frame end
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin wait_rise(); if (sdata_o) ok = 1'b0; end
    chk(ok, "R2 idle line after frame", 256'(ok), 256'(1));

    // R11 non-matching writes leave the link running
    @(negedge clk); pwr_wr_i = 1; pwr_addr_i = 7'h26; pwr_data_i = 16'hefff;
    @(negedge clk); pwr_addr_i = 7'h24; pwr_data_i = 16'h1000;
    @(negedge clk); pwr_wr_i = 0;
    n = 0;
    repeat (8*HALF) begin @(negedge clk); if (bit_clk_o && !prev_b) n++; end
    chk(n > 0, "R11 link alive after other writes", 256'(n), 256'(1));
    codec_ready_i = 1; stat_valid_i = 1; stat_addr_i = 7'h26; stat_data_i = 16'h0f0f;
    left_valid_i = 1; left_i = 18'h00001; right_valid_i = 1; right_i = 18'h20000;
    start_frame(); do_frame(1'b0, 1'b0);

    // R10 power-down mid-frame
    randomize_inputs(); codec_ready_i = 1;
    start_frame();
    for (int i = 0; i < 50; i++) begin wait_rise(); if (i == 15) sync_i = 0; end
    mon_en = 1'b0;
    @(negedge clk); pwr_wr_i = 1; pwr_addr_i = 7'h26; pwr_data_i = 16'h1000;
    @(negedge clk); pwr_wr_i = 0;
    @(negedge clk);
    chk(!bit_clk_o && !sdata_o, "R10 outputs low after power-down",
        256'({bit_clk_o, sdata_o}), 256'(0));
    ok = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      sync_i = (i % 64) < 16;
      if (bit_clk_o || sdata_o) ok = 1'b0;
    end
    sync_i = 0;
    chk(ok, "R10 outputs stay low with sync toggling", 256'(ok), 256'(1));

    // R11 reset leaves power-down
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!bit_clk_o && !sdata_o, "R12 outputs during reset",
        256'({bit_clk_o, sdata_o}), 256'(0));
    rst_n = 1;
    @(negedge clk);
    mon_en = 1'b1;
    codec_ready_i = 1; stat_valid_i = 1; stat_addr_i = 7'h02; stat_data_i = 16'h8001;
    left_valid_i = 1; left_i = 18'h30003; right_valid_i = 0; right_i = 18'h3ffff;
    start_frame(); do_frame(1'b0, 1'b0);

    chk(mon_bad == 0, "R1 data moves only on bit clock rise", 256'(mon_bad), 256'(0));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800us;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule